// File: doc/BRIEF.md
# Direction-Aware DMA Bus Arbiter

This block decides, once per transfer cycle, which DMA requester owns a shared bus. The requesters are a group of peripheral channels and a group of memory-to-memory streams. Each request comes with a direction bit. Peripheral channels always rank above memory streams. Inside each group, a lower index means higher priority.

Changing between reads and writes on an external bus costs turnaround cycles. To save them, the arbiter can keep serving one direction for a programmed number of transfers. While it does, it sets aside higher-priority requests that go the other way, so latency is traded for fewer turnarounds. The memory streams can also take turns: each stream keeps the bus for a fixed quota of transfers before the next stream gets it.

The direction preference is a two-state machine with states `ST_RD` and `ST_WR`. It has three transitions:
- `T_HOLD` keeps the state.
- `T_EXPIRE` flips the state when the block count runs out.
- `T_FOLLOW` moves to the direction of the transfer just granted, when that direction differs from the preferred one.

Top module: `dir_bus_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant_o` is zero and `pref_dir_o` is 0 (read). The memory-stream turn pointer starts at stream 0.
- R2: The grant is registered. Requests sampled at a clock edge produce `grant_o` after that edge. The grant is one-hot when any request was present and zero when none was.
- R3: Among the requests considered, the lowest-numbered peripheral channel wins.
- R4: A considered peripheral request always beats every memory-stream request.
- R5: With `cfg_mem_rr` = 0, the lowest-numbered requesting memory stream wins, every time.
- R6: With `cfg_mem_rr` = 1, the stream whose turn it is keeps the grant for `cfg_mem_quota` memory grants. The turn then passes to the next stream in circular order. A quota of 0 counts as 1.
- R7: In turn mode, if the stream holding the turn is not requesting, the next requesting stream in circular order is granted. It takes the turn and this grant counts as the first of its quota.
- R8: With `cfg_dir_blocks` ≠ 0, requests whose direction matches `pref_dir_o` are the only ones considered, provided at least one exists. Normal priority applies among them. Direction bit 1 means write, 0 means read.
- R9: If no request matches the preferred direction, the highest-priority opposite request is granted (`T_FOLLOW`). The preference switches to that direction and the block counter reloads. This switching transfer is not counted.
- R10: Each granted transfer in the preferred direction counts down. After `cfg_dir_blocks` of them the preference flips (`T_EXPIRE`), even if more requests in the same direction are pending, and the counter reloads.
- R11: With `cfg_dir_blocks` = 0, direction control is off. Plain priority applies, and `pref_dir_o` follows the direction of the last granted transfer.
- R12: A cycle with no requests leaves `pref_dir_o` and the block count unchanged (`T_HOLD`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NP+NM | Requests; bits 0..NP-1 are peripheral channels, the upper bits are memory streams |
| dir_i | input | NP+NM | Direction of each request, 1 = write |
| cfg_dir_blocks | input | CW | Transfers per preferred direction; 0 disables direction control |
| cfg_mem_rr | input | 1 | 1 = memory streams take turns, 0 = fixed priority |
| cfg_mem_quota | input | QW | Transfers per memory-stream turn |
| grant_o | output | NP+NM | One-hot registered grant |
| pref_dir_o | output | 1 | Current preferred direction, 1 = write |

## Verification
The direction filter and the priority order act in the same cycle. The sharpest case is when a higher-priority channel requests against the preferred direction while a lower-priority one requests with it. The bench holds such a pair through a full block count, checks that the lower channel wins until expiry, and checks that the flip then hands the grant to the higher one. An idle cycle is also placed inside a count. The bench confirms that the flip still lands after exactly the programmed number of granted transfers.

// File: rtl/dba_pkg.sv
package dba_pkg;
    typedef enum logic {
        ST_RD = 1'b0,
        ST_WR = 1'b1
    } dir_state_e;
endpackage

// File: rtl/dba_prio_pick.sv
module dba_prio_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] mask,
    output logic [W-1:0] onehot,
    output logic         any
);
    always_comb begin
        logic found;
        found  = 1'b0;
        onehot = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign any = |mask;
endmodule

// File: rtl/dba_mem_sched.sv
module dba_mem_sched #(
    parameter int NM = 2,
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rr,
    input  logic [QW-1:0] cfg_quota,
    input  logic [NM-1:0] mask,
    input  logic          adv,
    output logic [NM-1:0] pick
);
    localparam int PW = (NM > 1) ? $clog2(NM) : 1;

    logic [PW-1:0] ptr_q;
    logic [QW-1:0] used_q;
    logic [NM-1:0] fixed_oh;
    logic [NM-1:0] rr_oh;
    logic          fixed_any;
    logic [PW-1:0] win_idx;
    logic [QW-1:0] q_eff;

    dba_prio_pick #(.W(NM)) u_fixed (
        .mask   (mask),
        .onehot (fixed_oh),
        .any    (fixed_any)
    );

    always_comb begin
        logic found;
        found = 1'b0;
        rr_oh = '0;
        for (int i = 0; i < NM; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= NM) idx = idx - NM;
            if (mask[idx] && !found) begin
                rr_oh[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign pick  = cfg_rr ? rr_oh : fixed_oh;
    assign q_eff = (cfg_quota == '0) ? QW'(1) : cfg_quota;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NM; i++) begin
            if (rr_oh[i]) win_idx = PW'(i);
        end
    end

    function automatic logic [PW-1:0] next_idx(input logic [PW-1:0] cur);
        return (int'(cur) == NM - 1) ? '0 : cur + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            used_q <= '0;
        end else if (adv && cfg_rr && fixed_any) begin
            if (win_idx == ptr_q) begin
                if (used_q + QW'(1) >= q_eff) begin
                    ptr_q  <= next_idx(win_idx);
                    used_q <= '0;
                end else begin
                    used_q <= used_q + QW'(1);
                end
            end else if (q_eff == QW'(1)) begin
                ptr_q  <= next_idx(win_idx);
                used_q <= '0;
            end else begin
                ptr_q  <= win_idx;
                used_q <= QW'(1);
            end
        end
    end
endmodule

// File: rtl/dir_bus_arbiter.sv
module dir_bus_arbiter #(
    parameter int NP = 4,
    parameter int NM = 2,
    parameter int CW = 4,
    parameter int QW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP+NM-1:0] req_i,
    input  logic [NP+NM-1:0] dir_i,
    input  logic [CW-1:0]    cfg_dir_blocks,
    input  logic             cfg_mem_rr,
    input  logic [QW-1:0]    cfg_mem_quota,
    output logic [NP+NM-1:0] grant_o,
    output logic             pref_dir_o
);
    import dba_pkg::*;

    localparam int N = NP + NM;

    dir_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [N-1:0]  grant_q;

    logic          dirctl_on;
    logic [N-1:0]  match_mask;
    logic [N-1:0]  cand;
    logic [NP-1:0] per_oh;
    logic          per_any;
    logic [NM-1:0] mem_oh;
    logic          any_req;
    logic [N-1:0]  sel;
    logic          win_dir;

    assign dirctl_on  = (cfg_dir_blocks != '0);
    assign match_mask = req_i & (state_q == ST_WR ? dir_i : ~dir_i);
    assign cand       = (dirctl_on && (|match_mask)) ? match_mask : req_i;
    assign any_req    = |req_i;

    dba_prio_pick #(.W(NP)) u_periph (
        .mask   (cand[NP-1:0]),
        .onehot (per_oh),
        .any    (per_any)
    );

    dba_mem_sched #(.NM(NM), .QW(QW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rr    (cfg_mem_rr),
        .cfg_quota (cfg_mem_quota),
        .mask      (cand[N-1:NP]),
        .adv       (!per_any),
        .pick      (mem_oh)
    );

    assign sel     = per_any ? {{NM{1'b0}}, per_oh} : {mem_oh, {NP{1'b0}}};
    assign win_dir = |(sel & dir_i);

    // next-state: T_HOLD / T_EXPIRE / T_FOLLOW
    always_comb begin
        logic [CW-1:0] eff;
        state_d = state_q;
        cnt_d   = cnt_q;
        eff     = (cnt_q == '0) ? cfg_dir_blocks : cnt_q;
        if (!dirctl_on) begin
            cnt_d = '0;
            if (any_req) state_d = win_dir ? ST_WR : ST_RD;
        end else if (any_req) begin
            if (win_dir != (state_q == ST_WR)) begin
                state_d = win_dir ? ST_WR : ST_RD;
                cnt_d   = cfg_dir_blocks;
            end else if (eff == CW'(1)) begin
                unique case (state_q)
                    ST_RD: state_d = ST_WR;
                    ST_WR: state_d = ST_RD;
                endcase
                cnt_d = cfg_dir_blocks;
            end else begin
                cnt_d = eff - CW'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= any_req ? sel : '0;
    end

    assign grant_o    = grant_q;
    assign pref_dir_o = (state_q == ST_WR);
endmodule

// File: rtl/dir_bus_arbiter_chk.sv
module dir_bus_arbiter_chk #(
    parameter int NP = 4,
    parameter int NM = 2,
    parameter int CW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP+NM-1:0] req_i,
    input logic [NP+NM-1:0] dir_i,
    input logic [CW-1:0]    cfg_dir_blocks,
    input logic [NP+NM-1:0] grant_o,
    input logic             pref_dir_o
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (grant_o == '0));

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ($countones(grant_o) == 1));

    p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> ((grant_o & $past(req_i)) != '0));

    p_periph_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i[NP-1:0] != '0) && (cfg_dir_blocks == '0)) |=> (grant_o[NP-1:0] != '0));

    p_follow_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i != '0) && (cfg_dir_blocks == '0)) |=> (pref_dir_o == |(grant_o & $past(dir_i))));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> $stable(pref_dir_o));
endmodule

bind dir_bus_arbiter dir_bus_arbiter_chk #(.NP(NP), .NM(NM), .CW(CW)) u_chk (.*);

// File: tb/dir_bus_arbiter_tb_top.sv
module dir_bus_arbiter_tb_top;
    localparam int NP = 4;
    localparam int NM = 2;
    localparam int N  = NP + NM;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] dir_i = '0;
    logic [3:0]   cfg_dir_blocks = '0;
    logic         cfg_mem_rr = 1'b0;
    logic [3:0]   cfg_mem_quota = 4'd1;
    logic [N-1:0] grant_o;
    logic         pref_dir_o;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    logic [N-1:0] q_g[$];
    logic         q_p[$];
    string        q_t[$];

    always #10 clk = ~clk;

    dir_bus_arbiter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .dir_i          (dir_i),
        .cfg_dir_blocks (cfg_dir_blocks),
        .cfg_mem_rr     (cfg_mem_rr),
        .cfg_mem_quota  (cfg_mem_quota),
        .grant_o        (grant_o),
        .pref_dir_o     (pref_dir_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(string tag, logic [N-1:0] g, logic p, logic [N-1:0] eg, logic ep);
        checks++;
        if (g !== eg || p !== ep) begin
            failures++;
            $display("FAIL %s grant=%b pref=%b expected grant=%b pref=%b", tag, g, p, eg, ep);
        end
    endtask

    // driver: apply one transfer cycle and queue its expected outcome
    task automatic step(logic [N-1:0] r, logic [N-1:0] d, logic [N-1:0] eg, logic ep, string tag);
        @(negedge clk);
        req_i = r;
        dir_i = d;
        q_g.push_back(eg);
        q_p.push_back(ep);
        q_t.push_back(tag);
    endtask

    // idle cycle used to change configuration safely
    task automatic set_cfg(logic [3:0] blocks, logic rr, logic [3:0] quota);
        @(negedge clk);
        req_i = '0;
        dir_i = '0;
        cfg_dir_blocks = blocks;
        cfg_mem_rr = rr;
        cfg_mem_quota = quota;
    endtask

    // monitor: compare after each active edge
    always @(posedge clk) begin
        #1;
        if (q_g.size() > 0) begin
            logic [N-1:0] eg;
            logic         ep;
            string        t;
            eg = q_g.pop_front();
            ep = q_p.pop_front();
            t  = q_t.pop_front();
            check(t, grant_o, pref_dir_o, eg, ep);
        end
    end

    initial begin
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", grant_o, pref_dir_o, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle", grant_o, pref_dir_o, '0, 1'b0);

        // priority, direction control off
        step(6'b000000, 6'b000000, 6'b000000, 1'b0, "R2 no request");
        step(6'b001010, 6'b000000, 6'b000010, 1'b0, "R3 lowest peripheral");
        step(6'b111000, 6'b000000, 6'b001000, 1'b0, "R4 peripheral over memory");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R5 fixed memory");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R5 fixed memory repeat");
        step(6'b001000, 6'b001000, 6'b001000, 1'b1, "R11 follow write");
        step(6'b000000, 6'b000000, 6'b000000, 1'b1, "R12 idle hold");

        // turn mode, quota 2
        set_cfg(4'd0, 1'b1, 4'd2);
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R6 stream0 first");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R6 stream0 second");
        step(6'b110000, 6'b000000, 6'b100000, 1'b0, "R6 stream1 first");
        step(6'b110000, 6'b000000, 6'b100000, 1'b0, "R6 stream1 second");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R6 wrap to stream0");
        step(6'b100000, 6'b000000, 6'b100000, 1'b0, "R7 holder absent");
        step(6'b110000, 6'b000000, 6'b100000, 1'b0, "R7 takeover quota");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R7 turn passes");

        // quota 0 counts as 1
        set_cfg(4'd0, 1'b1, 4'd0);
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R6 quota0 stream0");
        step(6'b110000, 6'b000000, 6'b100000, 1'b0, "R6 quota0 stream1");
        step(6'b110000, 6'b000000, 6'b010000, 1'b0, "R6 quota0 stream0 again");

        // direction control, 3 blocks; ch0 write, ch1 read
        set_cfg(4'd3, 1'b0, 4'd1);
        step(6'b000011, 6'b000001, 6'b000010, 1'b0, "R8 read preferred 1");
        step(6'b000011, 6'b000001, 6'b000010, 1'b0, "R8 read preferred 2");
        step(6'b000011, 6'b000001, 6'b000010, 1'b1, "R10 expire to write");
        step(6'b000011, 6'b000001, 6'b000001, 1'b1, "R10 write 1");
        step(6'b000011, 6'b000001, 6'b000001, 1'b1, "R10 write 2");
        step(6'b000011, 6'b000001, 6'b000001, 1'b0, "R10 expire to read");
        step(6'b000011, 6'b000001, 6'b000010, 1'b0, "R8 read after flip");
        step(6'b000100, 6'b000100, 6'b000100, 1'b1, "R9 follow opposite");
        step(6'b000011, 6'b000001, 6'b000001, 1'b1, "R9 reload count 1");
        step(6'b000000, 6'b000000, 6'b000000, 1'b1, "R12 idle inside count");
        step(6'b000011, 6'b000001, 6'b000001, 1'b1, "R12 count 2");
        step(6'b000011, 6'b000001, 6'b000001, 1'b0, "R12 count 3 expires");
        step(6'b001110, 6'b000010, 6'b000100, 1'b0, "R8 priority within read");

        @(negedge clk);
        req_i = '0;
        repeat (3) @(negedge clk);
        report();
    end
endmodule